// File: doc/BRIEF.md
# Fixed-Priority Bus Arbiter with Lock Hold

This block shares one bus among a set of masters (four by default) at a fixed priority. Master 0 has the highest priority and the last master has the lowest. Each master asks for the bus with an active-low request line. The block answers with one active-low grant line per master, and at most one grant is low at any time. One clock drives the block, and an active-low reset clears it.

The master that owns the bus can hold it by driving the shared active-low lock input. While the lock is held, the owner keeps its grant. Lower-priority requests do not take it away, and neither does the owner dropping its own request. A higher-priority request is different. It takes the grant away from the owner at once, but the new master's grant is not issued while the lock is still held. Every grant stays inactive until the lock is released. On the first clock edge with the lock released, the grant goes to the highest-priority pending request.

Every grant decision is registered. A change on the inputs appears on the grant outputs after the next rising clock edge.

Top module: `arb_fixed_lock`

## Requirements
- R1: While reset is asserted, and after it is released until a request is granted, all grant outputs are high (inactive).
- R2: At most one grant output is low in any cycle.
- R3: With the lock released (lock_n high), after a clock edge the grant is low for the lowest-numbered master whose request is low. Master index 0 has the highest priority.
- R4: With the lock released and no request low, all grants are high after the next clock edge. This also applies when the previous owner has just dropped its request.
- R5: With the lock held (lock_n low) and a grant active, the grant stays on the same master after the clock edge when no lower-numbered master is requesting. This holds even if the owner drops its request or higher-numbered masters request.
- R6: With the lock held and a grant active, a request from any lower-numbered master makes all grants high after the next clock edge.
- R7: With the lock held and no grant active, no grant is issued, whatever the requests are.
- R8: On the first clock edge with the lock released after a lock period, the grant goes to the highest-priority master that is requesting, following R3 and R4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_n | input | NUM_MASTERS | Active-low bus requests; bit 0 has the highest priority |
| lock_n | input | 1 | Active-low bus lock from the current owner |
| gnt_n | output | NUM_MASTERS | Active-low bus grants, at most one low |

## Verification
The only state in the block is the registered grant vector, so any wrong internal state shows up directly on gnt_n in the same cycle. There is no hidden state that could stay wrong for a while before it is seen. A wrong hold, revoke or handover decision therefore shows up one clock edge after the inputs that caused it. The bench checks gnt_n against its own model at every such edge. It uses directed lock and priority sequences and a long pseudo-random run in which the lock is held often.

// File: rtl/arb_pkg.sv
package arb_pkg;

   // Grant-path decision taken at each rising clock edge.
   typedef enum logic [1:0] {
      ARB_PICK   = 2'd0,  // lock released: grant the best pending request
      ARB_HOLD   = 2'd1,  // lock held, owner kept
      ARB_REVOKE = 2'd2,  // lock held, higher request seen: drop owner
      ARB_WAIT   = 2'd3   // lock held, nobody owns: issue nothing
   } arb_action_e;

   localparam int unsigned ARB_MIN_MASTERS = 2;
   localparam int unsigned ARB_MAX_MASTERS = 64;

endpackage

// File: rtl/arb_prio_pick.sv
module arb_prio_pick #(
   parameter int unsigned NUM_MASTERS = 4
) (
   input  logic [NUM_MASTERS-1:0] req,
   output logic [NUM_MASTERS-1:0] win,
   output logic                   win_any
);

   // blocked[i] is set when any index below i is requesting.
   logic [NUM_MASTERS:0] blocked;

   assign blocked[0] = 1'b0;

   generate
      for (genvar gi = 0; gi < NUM_MASTERS; gi++) begin : g_chain
         assign blocked[gi+1] = blocked[gi] | req[gi];
         assign win[gi]       = req[gi] & ~blocked[gi];
      end
   endgenerate

   assign win_any = blocked[NUM_MASTERS];

endmodule

// File: rtl/arb_grant_ctl.sv
module arb_grant_ctl
   import arb_pkg::*;
#(
   parameter int unsigned NUM_MASTERS = 4
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [NUM_MASTERS-1:0] req,
   input  logic                   lock,
   input  logic [NUM_MASTERS-1:0] win,
   input  logic                   win_any,
   output logic [NUM_MASTERS-1:0] gnt
);

   logic [NUM_MASTERS-1:0] gnt_q;
   logic [NUM_MASTERS-1:0] gnt_d;
   logic [NUM_MASTERS-1:0] hi_mask;
   logic                   seen;
   logic                   owned;
   logic                   higher_req;
   arb_action_e            action;

   // hi_mask marks every index with more priority than the current owner.
   always_comb begin
      seen = 1'b0;
      for (int i = NUM_MASTERS - 1; i >= 0; i--) begin
         hi_mask[i] = seen;
         seen       = seen | gnt_q[i];
      end
   end

   assign owned      = |gnt_q;
   assign higher_req = |(req & hi_mask);

   always_comb begin
      if (lock && owned)
         action = higher_req ? ARB_REVOKE : ARB_HOLD;
      else if (lock)
         action = ARB_WAIT;
      else
         action = ARB_PICK;
   end

   always_comb begin
      unique case (action)
         ARB_HOLD:   gnt_d = gnt_q;
         ARB_REVOKE: gnt_d = '0;
         ARB_WAIT:   gnt_d = '0;
         default:    gnt_d = win_any ? win : '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         gnt_q <= '0;
      else
         gnt_q <= gnt_d;
   end

   assign gnt = gnt_q;

   a_r2_one_owner: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(gnt_q));

   a_r5_lock_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (lock && owned && !(|(req & hi_mask))) |=> $stable(gnt_q));

   a_r6_revoke: assert property (@(posedge clk) disable iff (!rst_n)
      (lock && owned && |(req & hi_mask)) |=> (gnt_q == '0));

   a_r7_lock_wait: assert property (@(posedge clk) disable iff (!rst_n)
      (lock && !owned) |=> (gnt_q == '0));

   a_r4_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (!lock && (req == '0)) |=> (gnt_q == '0));

endmodule

// File: rtl/arb_fixed_lock.sv
module arb_fixed_lock
   import arb_pkg::*;
#(
   parameter int unsigned NUM_MASTERS = 4
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [NUM_MASTERS-1:0] req_n,
   input  logic                   lock_n,
   output logic [NUM_MASTERS-1:0] gnt_n
);

   generate
      if (NUM_MASTERS < ARB_MIN_MASTERS || NUM_MASTERS > ARB_MAX_MASTERS) begin : g_bad_cfg
         $error("arb_fixed_lock: NUM_MASTERS out of range");
      end
   endgenerate

   logic [NUM_MASTERS-1:0] req;
   logic [NUM_MASTERS-1:0] win;
   logic [NUM_MASTERS-1:0] gnt;
   logic                   win_any;
   logic                   lock;

   assign req  = ~req_n;
   assign lock = ~lock_n;

   arb_prio_pick #(
      .NUM_MASTERS (NUM_MASTERS)
   ) u_pick (
      .req     (req),
      .win     (win),
      .win_any (win_any)
   );

   arb_grant_ctl #(
      .NUM_MASTERS (NUM_MASTERS)
   ) u_ctl (
      .clk     (clk),
      .rst_n   (rst_n),
      .req     (req),
      .lock    (lock),
      .win     (win),
      .win_any (win_any),
      .gnt     (gnt)
   );

   assign gnt_n = ~gnt;

   // R3/R8: with the lock released, the registered grant follows the picker.
   a_r3_pick_highest: assert property (@(posedge clk) disable iff (!rst_n)
      (lock_n && (req_n != '1)) |=> (gnt == $past(win)));

   a_r2_win_single: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(win));

endmodule

// File: tb/arb_fixed_lock_bench.sv
module arb_fixed_lock_bench;

   localparam int N = 4;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [N-1:0] req_n = '1;
   logic         lock_n = 1'b1;
   logic [N-1:0] gnt_n;

   int checks = 0;
   int fails  = 0;
   int owner  = -1;
   bit prev_lock = 1'b0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   arb_fixed_lock #(.NUM_MASTERS(N)) u_arb_fixed_lock (
      .clk    (clk),
      .rst_n  (rst_n),
      .req_n  (req_n),
      .lock_n (lock_n),
      .gnt_n  (gnt_n)
   );

   function automatic int best(input logic [N-1:0] r);
      for (int i = 0; i < N; i++)
         if (r[i]) return i;
      return -1;
   endfunction

   function automatic logic [N-1:0] expect_vec(input int o);
      logic [N-1:0] v;
      v = '1;
      if (o >= 0) v[o] = 1'b0;
      return v;
   endfunction

   task automatic check(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s gnt_n actual=%b expected=%b", tag, act, exp);
      end
   endtask

   // r and l are active high here; one clock edge per call.
   task automatic step(input logic [N-1:0] r, input logic l);
      int    top;
      string tag;
      req_n  = ~r;
      lock_n = ~l;
      @(posedge clk);
      top = best(r);
      if (l && owner >= 0) begin
         if (top >= 0 && top < owner) begin owner = -1; tag = "R6"; end
         else tag = "R5";
      end else if (l) begin
         tag = "R7";
      end else begin
         owner = top;
         if (prev_lock) tag = "R8";
         else tag = (top < 0) ? "R4" : "R3";
      end
      prev_lock = l;
      @(negedge clk);
      check(tag, gnt_n, expect_vec(owner));
      checks++;
      if ($countones(~gnt_n) > 1) begin
         fails++;
         $display("FAIL R2 gnt_n actual=%b expected=at most one low", gnt_n);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check("R1", gnt_n, '1);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", gnt_n, '1);

      // R3 priority order, R4 release
      step(4'b0010, 1'b0);
      step(4'b0110, 1'b0);
      step(4'b0111, 1'b0);
      step(4'b0100, 1'b0);
      step(4'b1100, 1'b0);
      step(4'b0000, 1'b0);
      step(4'b1000, 1'b0);
      // R5 hold under lock, R6 revoke, R7 wait, R8 handover
      step(4'b1000, 1'b1);
      step(4'b0000, 1'b1);
      step(4'b0100, 1'b1);
      step(4'b0100, 1'b1);
      step(4'b0001, 1'b1);
      step(4'b0101, 1'b0);
      step(4'b0100, 1'b0);
      step(4'b1100, 1'b1);
      step(4'b1000, 1'b1);
      step(4'b0000, 1'b0);
      step(4'b0000, 1'b1);
      step(4'b0000, 1'b0);

      for (int k = 0; k < 600; k++) begin
         logic [N-1:0] r;
         logic         l;
         r = N'($urandom_range(0, (1 << N) - 1));
         l = ($urandom_range(0, 9) < 6);
         step(r, l);
      end

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      #100000;
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

endmodule